// File: doc/BRIEF.md
# Standby STOP-Mode Controller

This block decides when a small microcontroller may drop into its deepest standby state and how it climbs back out. Software must first unlock a byte-wide gate register with two writes in a fixed order. Only then does setting the STOP bit of the standby control register take effect. In STOP, both oscillator enables and both clock-gate enables drop low.

One of four enabled wake requests ends STOP. The controller clears the STOP bit and restarts the low-speed oscillator. It restarts the high-speed oscillator only if that oscillator was running when STOP was entered. Each oscillator then has its own pulse count that must complete before its clock is released. The low-speed count also marks the return to run mode.

The oscillator pulse inputs are strobes in the `clk` domain. Every cycle in which a strobe is high counts as one oscillator pulse.

Top module: `stby_stop_ctrl`

## Requirements
- R1: After reset the mode is run (0) and STP is 0. The low-speed oscillator enable and the low-speed clock gate are 1. The high-speed oscillator enable and the high-speed clock gate are 0.
- R2: A write to the gate register (`wr_sel`=0) whose upper nibble is 0x5, followed by a write to it whose upper nibble is 0xA, unlocks STOP entry. The lower nibble of either write does not matter.
- R3: While locked, a write to the control register (`wr_sel`=1) with bit 0 set leaves the mode in run and STP at 0.
- R4: If the gate-register write right after an accepted 0x5 write does not carry 0xA in its upper nibble, the sequencer returns to idle. A following 0xA write then does not unlock.
- R5: When unlocked, a control write with bit 0 set changes the outputs at the next clock edge. The mode becomes stop (1) and STP becomes 1. Both oscillator enables and both clock gates become 0.
- R6: Entering STOP relocks the gate. After wake-up, a STP write made without a new unlock sequence has no effect.
- R7: In stop, any wake request bit whose enable bit is 1 moves the outputs at the next edge. The mode becomes stabilizing (2), STP becomes 0 and the low-speed oscillator enable becomes 1. A request with its enable bit at 0 has no effect, and wake requests have no effect outside stop.
- R8: On wake-up, the high-speed oscillator enable becomes 1 only if it was 1 when STOP was entered. Otherwise it stays 0 until the mode is run again.
- R9: In stabilizing, the mode stays stabilizing through 8191 low-speed pulses. The edge that samples the 8192nd pulse, plus one more edge, moves the mode to run and sets the low-speed clock gate to 1.
- R10: The high-speed clock gate becomes 1 only when all of the following hold: the mode is run, the high-speed oscillator is enabled, and 16 high-speed pulses have been counted since it was enabled. It becomes 1 right after the edge that samples the 16th pulse, or on entry to run if the count finished earlier.
- R11: A wake request lasting a single cycle is enough to complete the whole wake sequence.
- R12: In run, the high-speed oscillator enable follows `hs_run_req` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the gate register, 1 selects the control register |
| wr_data | input | 8 | Write data |
| wake_req | input | 4 | Wake interrupt requests |
| wake_ien | input | 4 | Per-request interrupt enable flags |
| ls_pulse | input | 1 | Low-speed oscillator pulse strobe |
| hs_pulse | input | 1 | High-speed oscillator pulse strobe |
| hs_run_req | input | 1 | Software request to run the high-speed oscillator |
| ls_osc_en | output | 1 | Low-speed oscillator enable |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ls_clk_gate | output | 1 | Low-speed clock supply enable |
| hs_clk_gate | output | 1 | High-speed clock supply enable |
| stp | output | 1 | STOP status bit |
| mode | output | 2 | 0 run, 1 stop, 2 stabilizing |

## Verification
On every cycle, the assertions check these properties:
- the oscillators are off while in stop;
- STP is set only in stop;
- entry into stop only ever follows an unlocked gate;
- the gate relocks after entry;
- an enabled wake always leaves stop;
- the stabilization counters never pass their limits.

Only the directed scenarios can show the exact pulse counts of 8192 and 16 at their boundaries. The same holds for the rejection of broken or missing unlock sequences, and for the choice, made at entry, of whether the high-speed oscillator returns.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_STOP   = 2'd1,
    MODE_SETTLE = 2'd2
  } stby_mode_e;

  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_HALF = 2'd1,
    GATE_OPEN = 2'd2
  } gate_state_e;
endpackage

// File: rtl/stby_unlock.sv
module stby_unlock
  import stby_pkg::*;
#(
  parameter logic [3:0] KEY_FIRST  = 4'h5,
  parameter logic [3:0] KEY_SECOND = 4'hA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gate_wr,
  input  logic [3:0] gate_nib,
  input  logic       consume,
  output logic       unlocked
);
  gate_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst || consume) begin
      state_q <= GATE_IDLE;
    end else if (gate_wr) begin
      case (state_q)
        GATE_IDLE: state_q <= (gate_nib == KEY_FIRST) ? GATE_HALF : GATE_IDLE;
        GATE_HALF: state_q <= (gate_nib == KEY_SECOND) ? GATE_OPEN : GATE_IDLE;
        GATE_OPEN: state_q <= GATE_OPEN;
        default:   state_q <= GATE_IDLE;
      endcase
    end
  end

  assign unlocked = (state_q == GATE_OPEN);

  AST_RELOCK_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    consume |=> !unlocked); // R6

  AST_OPEN_NEEDS_SECOND_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(gate_wr) && ($past(gate_nib) == KEY_SECOND)); // R2
endmodule

// File: rtl/stby_settle.sv
module stby_settle #(
  parameter int unsigned COUNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pulse,
  output logic done
);
  localparam int unsigned CW = $clog2(COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);
  localparam logic [CW-1:0] FULL = CW'(COUNT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (!done && pulse) begin
      if (cnt_q == LAST) begin
        cnt_q <= FULL;
        done  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL); // R9

  AST_DONE_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(pulse) && $past(en)); // R10
endmodule

// File: rtl/stby_stop_ctrl.sv
module stby_stop_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned NWAKE     = 4,
  parameter int unsigned LS_SETTLE = 8192,
  parameter int unsigned HS_SETTLE = 16,
  parameter int unsigned STP_BIT   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [NWAKE-1:0] wake_req,
  input  logic [NWAKE-1:0] wake_ien,
  input  logic             ls_pulse,
  input  logic             hs_pulse,
  input  logic             hs_run_req,
  output logic             ls_osc_en,
  output logic             hs_osc_en,
  output logic             ls_clk_gate,
  output logic             hs_clk_gate,
  output logic             stp,
  output logic [1:0]       mode
);
  localparam int unsigned NIB_LO = DW - 4;

  stby_mode_e mode_q;
  logic       hs_saved_q;
  logic       unlocked;
  logic       ls_done;
  logic       hs_done;
  logic       wake_hit;
  logic       stp_wr;
  logic       gate_wr;
  logic       enter;

  assign wake_hit = |(wake_req & wake_ien);
  assign stp_wr   = wr_en && wr_sel && wr_data[STP_BIT];
  assign gate_wr  = wr_en && !wr_sel;
  assign enter    = (mode_q == MODE_RUN) && stp_wr && unlocked;

  stby_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .gate_wr  (gate_wr),
    .gate_nib (wr_data[DW-1:NIB_LO]),
    .consume  (enter),
    .unlocked (unlocked)
  );

  stby_settle #(.COUNT(LS_SETTLE)) u_ls_settle (
    .clk   (clk),
    .rst   (rst),
    .en    (mode_q == MODE_SETTLE),
    .pulse (ls_pulse),
    .done  (ls_done)
  );

  stby_settle #(.COUNT(HS_SETTLE)) u_hs_settle (
    .clk   (clk),
    .rst   (rst),
    .en    (hs_osc_en),
    .pulse (hs_pulse),
    .done  (hs_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_RUN;
      stp        <= 1'b0;
      ls_osc_en  <= 1'b1;
      hs_osc_en  <= 1'b0;
      hs_saved_q <= 1'b0;
    end else begin
      case (mode_q)
        MODE_RUN: begin
          if (enter) begin
            mode_q     <= MODE_STOP;
            stp        <= 1'b1;
            ls_osc_en  <= 1'b0;
            hs_osc_en  <= 1'b0;
            hs_saved_q <= hs_osc_en;
          end else begin
            ls_osc_en <= 1'b1;
            hs_osc_en <= hs_run_req;
          end
        end
        MODE_STOP: begin
          if (wake_hit) begin
            mode_q    <= MODE_SETTLE;
            stp       <= 1'b0;
            ls_osc_en <= 1'b1;
            hs_osc_en <= hs_saved_q;
          end
        end
        MODE_SETTLE: begin
          if (ls_done) mode_q <= MODE_RUN;
        end
        default: mode_q <= MODE_RUN;
      endcase
    end
  end

  assign mode        = mode_q;
  assign ls_clk_gate = (mode_q == MODE_RUN);
  assign hs_clk_gate = (mode_q == MODE_RUN) && hs_osc_en && hs_done;

  AST_STOP_OSC_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP) |-> !ls_osc_en && !hs_osc_en); // R5

  AST_STP_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (rst)
    stp |-> (mode_q == MODE_STOP)); // R5

  AST_ENTRY_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP) && ($past(mode_q) == MODE_RUN) |-> $past(unlocked)); // R2

  AST_WAKE_LEAVES_STOP: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP) && wake_hit |=> (mode_q == MODE_SETTLE) && !stp && ls_osc_en); // R7

  AST_HS_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SETTLE) && !hs_saved_q |-> !hs_osc_en); // R8

  AST_LS_ON_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN) |-> ls_osc_en); // R9
endmodule

// File: tb/stby_stop_ctrl_test.sv
module stby_stop_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] wake_req = 4'h0;
  logic [3:0] wake_ien = 4'h0;
  logic       ls_pulse = 1'b0;
  logic       hs_pulse = 1'b0;
  logic       hs_run_req = 1'b0;
  logic       ls_osc_en, hs_osc_en, ls_clk_gate, hs_clk_gate, stp;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  stby_stop_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wake_req(wake_req), .wake_ien(wake_ien), .ls_pulse(ls_pulse),
    .hs_pulse(hs_pulse), .hs_run_req(hs_run_req), .ls_osc_en(ls_osc_en),
    .hs_osc_en(hs_osc_en), .ls_clk_gate(ls_clk_gate), .hs_clk_gate(hs_clk_gate),
    .stp(stp), .mode(mode)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // outputs as {mode, stp, ls_osc_en, hs_osc_en, ls_clk_gate, hs_clk_gate}
  function automatic logic [7:0] outs();
    return {1'b0, mode, stp, ls_osc_en, hs_osc_en, ls_clk_gate, hs_clk_gate};
  endfunction

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic ls_pulses(input int n);
    ls_pulse = 1'b1;
    repeat (n) @(negedge clk);
    ls_pulse = 1'b0;
  endtask

  task automatic hs_pulses(input int n);
    hs_pulse = 1'b1;
    repeat (n) @(negedge clk);
    hs_pulse = 1'b0;
  endtask

  task automatic unlock_and_stop();
    wr(1'b0, 8'h53);
    wr(1'b0, 8'hAC);
    wr(1'b1, 8'h01);
  endtask

  task automatic wake_one(input int idx);
    wake_ien = 4'hF;
    wake_req = 4'h0;
    wake_req[idx] = 1'b1;
    @(negedge clk);
    wake_req = 4'h0;
  endtask

  task automatic t_reset();
    // R1: run, stp 0, ls osc 1, hs osc 0, ls gate 1, hs gate 0
    chk("R1", "reset outputs", outs(), {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
  endtask

  task automatic t_locked_stp();
    wr(1'b1, 8'h01);
    chk("R3", "locked STP write", outs(), {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
  endtask

  task automatic t_broken_seq();
    wr(1'b0, 8'h5F);
    wr(1'b0, 8'h3A);
    wr(1'b0, 8'hA0);
    wr(1'b1, 8'h01);
    chk("R4", "broken sequence mode", {6'd0, mode}, 8'd0);
    chk("R4", "broken sequence stp", {7'd0, stp}, 8'd0);
  endtask

  task automatic t_wake_in_run();
    wake_ien = 4'hF; wake_req = 4'hF;
    repeat (3) @(negedge clk);
    wake_req = 4'h0;
    chk("R7", "wake ignored in run", {6'd0, mode}, 8'd0);
  endtask

  task automatic t_stop_ls_only();
    unlock_and_stop();
    // R5, R2: stop, stp 1, all off
    chk("R5", "stop outputs", outs(), {1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
    wake_ien = 4'b1101; wake_req = 4'b0010;
    repeat (4) @(negedge clk);
    wake_req = 4'h0;
    chk("R7", "masked wake ignored", {6'd0, mode}, 8'd1);
    wake_one(2);
    // R7, R8, R11: settle, stp 0, ls on, hs stays off
    chk("R7", "wake outputs", outs(), {1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
    hs_pulses(20);
    chk("R8", "hs off while settling", {7'd0, hs_osc_en}, 8'd0);
    ls_pulses(8191);
    chk("R9", "still settling after 8191", {6'd0, mode}, 8'd2);
    ls_pulses(1);
    chk("R9", "settling one edge after 8192nd", {6'd0, mode}, 8'd2);
    @(negedge clk);
    chk("R9", "run after 8192", outs(), {1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
    chk("R11", "single-cycle wake completed", {6'd0, mode}, 8'd0);
  endtask

  task automatic t_relock();
    wr(1'b1, 8'h01);
    chk("R6", "STP after wake without unlock", {6'd0, mode}, 8'd0);
    chk("R6", "stp bit stays 0", {7'd0, stp}, 8'd0);
  endtask

  task automatic t_stop_hs_ready_early();
    hs_run_req = 1'b1;
    @(negedge clk);
    chk("R12", "hs osc follows request", {7'd0, hs_osc_en}, 8'd1);
    hs_pulses(15);
    chk("R10", "hs gate before 16", {7'd0, hs_clk_gate}, 8'd0);
    hs_pulses(1);
    chk("R10", "hs gate at 16", {7'd0, hs_clk_gate}, 8'd1);
    unlock_and_stop();
    chk("R5", "hs off in stop", outs(), {1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
    wake_ien = 4'h1; wake_req = 4'h1;
    repeat (3) @(negedge clk);
    wake_req = 4'h0;
    chk("R8", "hs restored on wake", {7'd0, hs_osc_en}, 8'd1);
    hs_pulses(16);
    chk("R10", "hs gate held while settling", {7'd0, hs_clk_gate}, 8'd0);
    ls_pulses(8192);
    @(negedge clk);
    chk("R10", "hs gate with run entry", outs(), {1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1});
  endtask

  task automatic t_stop_hs_late();
    unlock_and_stop();
    wake_one(3);
    hs_pulses(10);
    ls_pulses(8192);
    @(negedge clk);
    chk("R9", "run entry", {6'd0, mode}, 8'd0);
    chk("R10", "hs gate waits for count", {7'd0, hs_clk_gate}, 8'd0);
    hs_pulses(5);
    chk("R10", "hs gate after 15", {7'd0, hs_clk_gate}, 8'd0);
    hs_pulses(1);
    chk("R10", "hs gate after 16", {7'd0, hs_clk_gate}, 8'd1);
    hs_run_req = 1'b0;
    @(negedge clk);
    chk("R12", "hs osc drops with request", {6'd0, hs_osc_en, hs_clk_gate}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_locked_stp();
    t_broken_seq();
    t_wake_in_run();
    t_stop_ls_only();
    t_relock();
    t_stop_hs_ready_early();
    t_stop_hs_late();
    done_flag = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_flag && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule